// File: doc/BRIEF.md
# Register-Amount Shifter with Carry-Out

This block shifts or rotates a 32-bit value by an amount taken from the low byte of a second 32-bit operand. It also produces the carry flag that follows the rules for a shift whose amount comes from a register. Four operations are supported: logical left, logical right, arithmetic right and rotate right. The shift type selects the operation. The current carry flag is an input, because some amounts leave the carry unchanged. Rotate-with-extend and the other flag updates are not part of this block.

A caller presents an operation with a one-cycle `in_valid` strobe. The result and new carry are registered and appear on the next clock edge, together with `out_valid`. Strobes may arrive back to back.

A two-state controller sets the output timing. `ST_IDLE` means no result is being presented. `ST_EMIT` means the result registers hold the answer to the previous cycle's strobe. The transitions are:
- `ACCEPT` (`ST_IDLE` to `ST_EMIT`) on a strobe.
- `CHAIN` (`ST_EMIT` to `ST_EMIT`) on a strobe while emitting.
- `DRAIN` (`ST_EMIT` to `ST_IDLE`) when there is no strobe.
- `REST` (`ST_IDLE` to `ST_IDLE`) when there is no strobe while idle.

Top module: `regamt_shifter`

## Requirements
- R1: Only bits [7:0] of `in_amount` affect the outputs; bits [31:8] are ignored.
- R2: When the amount byte is zero, the result equals `in_value` and the carry equals `in_carry`, for every shift type.
- R3: For type 2'b00 (logical left) and amount n in 1..31, the result is `in_value << n` and the carry is `in_value[32-n]`.
- R4: For type 2'b00, an amount of exactly 32 gives result 0 and carry `in_value[0]`; an amount of 33..255 gives result 0 and carry 0.
- R5: For type 2'b01 (logical right) and amount n in 1..31, the result is `in_value >> n` and the carry is `in_value[n-1]`.
- R6: For type 2'b01, an amount of exactly 32 gives result 0 and carry `in_value[31]`; an amount of 33..255 gives result 0 and carry 0.
- R7: For type 2'b10 (arithmetic right) and amount n in 1..31, the result is the sign-filled right shift and the carry is `in_value[n-1]`.
- R8: For type 2'b10 and an amount of 32..255, every result bit and the carry equal `in_value[31]`.
- R9: For type 2'b11 (rotate right), let r be the amount byte modulo 32. When r is nonzero, the result is `in_value` rotated right by r and the carry is `in_value[r-1]`.
- R10: For type 2'b11, when r is zero but the amount byte is nonzero, the result equals `in_value` and the carry equals `in_value[31]`.
- R11: The result, carry and `out_valid` (1) appear one cycle after a strobe. Without a strobe, `out_valid` is 0 in the next cycle and the result and carry hold their values.
- R12: After reset, `out_valid`, `out_result` and `out_carry` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| in_value | input | 32 | Value to shift |
| in_amount | input | 32 | Amount operand; only the low byte is used |
| in_kind | input | 2 | Shift type: 00 LSL, 01 LSR, 10 ASR, 11 ROR |
| in_carry | input | 1 | Current carry flag |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| out_result | output | 32 | Shifted value |
| out_carry | output | 1 | New carry flag |

## Verification
Presenting one result and capturing the next operation can happen in the same cycle, on the `CHAIN` transition. The vector table is driven with a strobe on every cycle, so every vector after the first is accepted while its predecessor is on the outputs. Each result is judged in the cycle after its own strobe against a value worked out by hand, so an output that lags or leads by a cycle shows up as a mismatch. A directed step then removes the strobe and changes the inputs. It checks that the `DRAIN` transition clears `out_valid` and that the result and carry do not move.

// File: rtl/regamt_shifter_pkg.sv
package regamt_shifter_pkg;

    typedef enum logic [1:0] {
        SH_LSL = 2'b00,
        SH_LSR = 2'b01,
        SH_ASR = 2'b10,
        SH_ROR = 2'b11
    } shift_kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } ctl_state_e;

endpackage

// File: rtl/regamt_amount_decode.sv
module regamt_amount_decode #(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  logic [AMT_W-1:0] amt,
    output logic             amt_zero,
    output logic             amt_exact,
    output logic             amt_over,
    output logic [SH_W-1:0]  amt_low
);
    localparam logic [AMT_W-1:0] FULL = AMT_W'(DATA_W);

    always_comb begin
        amt_zero  = (amt == '0);
        amt_exact = (amt == FULL);
        amt_over  = (amt > FULL);
        amt_low   = amt[SH_W-1:0];
    end
endmodule

// File: rtl/regamt_shift_core.sv
module regamt_shift_core
    import regamt_shifter_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] value,
    input  shift_kind_e       kind,
    input  logic              carry_in,
    input  logic              amt_zero,
    input  logic              amt_exact,
    input  logic              amt_over,
    input  logic [SH_W-1:0]   amt_low,
    output logic [DATA_W-1:0] res,
    output logic              carry
);
    logic [DATA_W:0]          lsl_ext;
    logic [DATA_W:0]          lsr_ext;
    logic signed [DATA_W:0]   asr_ext;
    logic [2*DATA_W-1:0]      ror_ext;
    logic                     msb;

    always_comb begin
        msb     = value[DATA_W-1];
        lsl_ext = {1'b0, value} << amt_low;
        lsr_ext = {value, 1'b0} >> amt_low;
        asr_ext = $signed({value, 1'b0}) >>> amt_low;
        ror_ext = {value, value} >> amt_low;

        res   = value;
        carry = carry_in;
        if (!amt_zero) begin
            unique case (kind)
                SH_LSL: begin
                    if (amt_exact) begin
                        res   = '0;
                        carry = value[0];
                    end else if (amt_over) begin
                        res   = '0;
                        carry = 1'b0;
                    end else begin
                        res   = lsl_ext[DATA_W-1:0];
                        carry = lsl_ext[DATA_W];
                    end
                end
                SH_LSR: begin
                    if (amt_exact) begin
                        res   = '0;
                        carry = msb;
                    end else if (amt_over) begin
                        res   = '0;
                        carry = 1'b0;
                    end else begin
                        res   = lsr_ext[DATA_W:1];
                        carry = lsr_ext[0];
                    end
                end
                SH_ASR: begin
                    if (amt_exact || amt_over) begin
                        res   = {DATA_W{msb}};
                        carry = msb;
                    end else begin
                        res   = asr_ext[DATA_W:1];
                        carry = asr_ext[0];
                    end
                end
                SH_ROR: begin
                    res   = ror_ext[DATA_W-1:0];
                    carry = ror_ext[DATA_W-1];
                end
                default: begin
                    res   = value;
                    carry = carry_in;
                end
            endcase
        end
    end
endmodule

// File: rtl/regamt_shifter.sv
module regamt_shifter
    import regamt_shifter_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_value,
    input  logic [DATA_W-1:0] in_amount,
    input  logic [1:0]        in_kind,
    input  logic              in_carry,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result,
    output logic              out_carry
);
    localparam int SH_W = $clog2(DATA_W);

    ctl_state_e        state_q, state_d;
    logic              amt_zero, amt_exact, amt_over;
    logic [SH_W-1:0]   amt_low;
    logic [DATA_W-1:0] core_res;
    logic              core_carry;
    logic [DATA_W-1:0] res_q;
    logic              carry_q;

    regamt_amount_decode #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_decode (
        .amt       (in_amount[AMT_W-1:0]),
        .amt_zero  (amt_zero),
        .amt_exact (amt_exact),
        .amt_over  (amt_over),
        .amt_low   (amt_low)
    );

    regamt_shift_core #(.DATA_W(DATA_W)) u_core (
        .value     (in_value),
        .kind      (shift_kind_e'(in_kind)),
        .carry_in  (in_carry),
        .amt_zero  (amt_zero),
        .amt_exact (amt_exact),
        .amt_over  (amt_over),
        .amt_low   (amt_low),
        .res       (core_res),
        .carry     (core_carry)
    );

    // Next-state logic: ACCEPT / CHAIN / DRAIN / REST
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = in_valid ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output registers: capture on every strobe, hold otherwise
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q   <= '0;
            carry_q <= 1'b0;
        end else if (in_valid) begin
            res_q   <= core_res;
            carry_q <= core_carry;
        end
    end

    always_comb begin
        out_valid  = (state_q == ST_EMIT);
        out_result = res_q;
        out_carry  = carry_q;
    end
endmodule

// File: rtl/regamt_shifter_chk.sv
module regamt_shifter_chk #(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_value,
    input logic [DATA_W-1:0] in_amount,
    input logic [1:0]        in_kind,
    input logic              in_carry,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_result,
    input logic              out_carry
);
    localparam logic [AMT_W-1:0] FULL = AMT_W'(DATA_W);
    localparam int SH_W = $clog2(DATA_W);

    // R11
    strobe_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_result) && $stable(out_carry)));

    // R2
    zero_amt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_amount[AMT_W-1:0] == '0) |=>
        (out_result == $past(in_value) && out_carry == $past(in_carry)));

    // R4
    lsl_over_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind == 2'b00 && in_amount[AMT_W-1:0] > FULL) |=>
        (out_result == '0 && !out_carry));

    // R6
    lsr_over_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind == 2'b01 && in_amount[AMT_W-1:0] > FULL) |=>
        (out_result == '0 && !out_carry));

    // R8
    asr_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind == 2'b10 && in_amount[AMT_W-1:0] >= FULL) |=>
        (out_result == {DATA_W{$past(in_value[DATA_W-1])}} &&
         out_carry == $past(in_value[DATA_W-1])));

    // R10
    ror_whole_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind == 2'b11 && in_amount[AMT_W-1:0] != '0 &&
         in_amount[SH_W-1:0] == '0) |=>
        (out_result == $past(in_value) && out_carry == $past(in_value[DATA_W-1])));

    // R12
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid || rst_n));
endmodule

bind regamt_shifter regamt_shifter_chk #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_value   (in_value),
    .in_amount  (in_amount),
    .in_kind    (in_kind),
    .in_carry   (in_carry),
    .out_valid  (out_valid),
    .out_result (out_result),
    .out_carry  (out_carry)
);

// File: tb/regamt_shifter_tb.sv
module regamt_shifter_tb;
    // vector: value(32) amount(32) kind(2) cin(1) exp_res(32) exp_c(1) req(8)
    localparam int NV = 21;
    localparam int VW = 32 + 32 + 2 + 1 + 32 + 1 + 8;
    localparam logic [VW-1:0] VEC [NV] = '{
        {32'h1000_0001, 32'd4,          2'b00, 1'b0, 32'h0000_0010, 1'b1, 8'd3},  // R3
        {32'h8000_0000, 32'd1,          2'b00, 1'b0, 32'h0000_0000, 1'b1, 8'd3},  // R3
        {32'h0000_0001, 32'd32,         2'b00, 1'b0, 32'h0000_0000, 1'b1, 8'd4},  // R4
        {32'hFFFF_FFFF, 32'd33,         2'b00, 1'b1, 32'h0000_0000, 1'b0, 8'd4},  // R4
        {32'h0000_0018, 32'd4,          2'b01, 1'b0, 32'h0000_0001, 1'b1, 8'd5},  // R5
        {32'h4000_0000, 32'd31,         2'b01, 1'b0, 32'h0000_0000, 1'b1, 8'd5},  // R5
        {32'h8000_0000, 32'd32,         2'b01, 1'b0, 32'h0000_0000, 1'b1, 8'd6},  // R6
        {32'hFFFF_FFFF, 32'd255,        2'b01, 1'b1, 32'h0000_0000, 1'b0, 8'd6},  // R6
        {32'h8000_0008, 32'd4,          2'b10, 1'b0, 32'hF800_0000, 1'b1, 8'd7},  // R7
        {32'h7FFF_FFFE, 32'd1,          2'b10, 1'b1, 32'h3FFF_FFFF, 1'b0, 8'd7},  // R7
        {32'h8000_0000, 32'd40,         2'b10, 1'b0, 32'hFFFF_FFFF, 1'b1, 8'd8},  // R8
        {32'h7FFF_FFFF, 32'd32,         2'b10, 1'b1, 32'h0000_0000, 1'b0, 8'd8},  // R8
        {32'h0000_0018, 32'd4,          2'b11, 1'b0, 32'h8000_0001, 1'b1, 8'd9},  // R9
        {32'h0000_0018, 32'd36,         2'b11, 1'b0, 32'h8000_0001, 1'b1, 8'd9},  // R9
        {32'h8000_0000, 32'd32,         2'b11, 1'b0, 32'h8000_0000, 1'b1, 8'd10}, // R10
        {32'h0000_0001, 32'd64,         2'b11, 1'b1, 32'h0000_0001, 1'b0, 8'd10}, // R10
        {32'hDEAD_BEEF, 32'd0,          2'b00, 1'b1, 32'hDEAD_BEEF, 1'b1, 8'd2},  // R2
        {32'h8000_0000, 32'd0,          2'b11, 1'b0, 32'h8000_0000, 1'b0, 8'd2},  // R2
        {32'h1234_5678, 32'd0,          2'b10, 1'b1, 32'h1234_5678, 1'b1, 8'd2},  // R2
        {32'h1000_0001, 32'hFFFF_FF04,  2'b00, 1'b0, 32'h0000_0010, 1'b1, 8'd1},  // R1
        {32'hABCD_0000, 32'h0000_0100,  2'b01, 1'b1, 32'hABCD_0000, 1'b1, 8'd1}   // R1
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_value = '0;
    logic [31:0] in_amount = '0;
    logic [1:0]  in_kind = '0;
    logic        in_carry = 1'b0;
    logic        out_valid;
    logic [31:0] out_result;
    logic        out_carry;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    regamt_shifter u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_value   (in_value),
        .in_amount  (in_amount),
        .in_kind    (in_kind),
        .in_carry   (in_carry),
        .out_valid  (out_valid),
        .out_result (out_result),
        .out_carry  (out_carry)
    );

    task automatic check(input int req, input logic v, input logic [31:0] r, input logic c);
        tests++;
        if (out_valid !== v || out_result !== r || out_carry !== c) begin
            fails++;
            $display("FAIL R%0d: got valid=%0b res=%h c=%0b, expected valid=%0b res=%h c=%0b",
                     req, out_valid, out_result, out_carry, v, r, c);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        check(12, 1'b0, 32'h0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check(12, 1'b0, 32'h0, 1'b0);

        // Vector table, strobe every cycle (CHAIN path)
        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            v = VEC[i];
            in_valid  = 1'b1;
            in_value  = v[VW-1 -: 32];
            in_amount = v[VW-33 -: 32];
            in_kind   = v[VW-65 -: 2];
            in_carry  = v[VW-67];
            @(negedge clk);
            check(int'(v[7:0]), 1'b1, v[40:9], v[8]);
        end

        // R11: drop strobe, change inputs, outputs must hold and valid drop
        in_valid  = 1'b0;
        in_value  = 32'hFFFF_FFFF;
        in_amount = 32'd3;
        in_kind   = 2'b00;
        in_carry  = 1'b0;
        @(negedge clk);
        check(11, 1'b0, 32'hABCD_0000, 1'b1);
        @(negedge clk);
        check(11, 1'b0, 32'hABCD_0000, 1'b1);

        // R11: single strobe from idle (ACCEPT), then DRAIN
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(11, 1'b1, 32'hFFFF_FFF8, 1'b1);
        @(negedge clk);
        check(11, 1'b0, 32'hFFFF_FFF8, 1'b1);

        // R12: asynchronous reset clears outputs
        rst_n = 1'b0;
        @(negedge clk);
        check(12, 1'b0, 32'h0, 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule